// File: doc/BRIEF.md
# Paged Command and Register Bank

This block is the host-facing register front end of a network controller. The host reaches it through a 4-bit offset and 8-bit read and write data. Offset 0 always holds the command byte. Its top two bits pick one of three register pages, and that page is what the other fifteen offsets reach. In page 0 a read and a write at the same offset usually reach different things. Writes load configuration that is driven out to the rest of the controller. Reads return live status that the controller feeds in. Page 1 holds the station address, the current receive page and the multicast hash filter. Page 2 reads back the configuration that page 0 only accepts as writes.

The low bits of the command byte control the controller itself. The stop and start bits move it into and out of an offline state, but going offline waits until the link datapath reports idle. The transmit request bit starts a frame and clears itself when the transmitter reports completion or abort. The remote DMA field starts or aborts the remote DMA engine through one-cycle strobes. All strobes are registered and appear in the cycle after the write edge. Reads are combinational from the offset and the stored command byte.

Top module: `pgb_bank`

## Requirements
- R1: After synchronous reset the command byte reads 0x21 (stop=1, remote DMA field 100, page 0), `offline` is 1, and every configuration, station, receive page and hash output is 0.
- R2: Command bits 7:6 select the page (00 page 0, 01 page 1, 10 page 2, 11 reserved). Offset 0 reads and writes the command byte whatever page is selected.
- R3: Page 0 writes load: 1 ring start, 2 ring stop, 3 boundary, 4 transmit page, 5/6 transmit count low/high, 8/9 remote start low/high, 0xA/0xB remote count low/high, 0xC receive config, 0xD transmit config, 0xE data config, 0xF interrupt mask. Page 0 reads return: 1/2 local DMA address low/high, 3 boundary, 4 transmit status, 5 collision count, 6 FIFO byte, 7 interrupt status, 8/9 remote DMA address low/high, 0xA/0xB 0x00, 0xC receive status, 0xD/0xE/0xF tally bytes 0/1/2 (`stat_tally` bits 7:0, 15:8, 23:16).
- R4: In page 1, offsets 1–6 read and write station byte 0–5 (byte i on `station_addr[8i+7:8i]`). Offset 7 reads and writes the current receive page. Offsets 8–15 read and write hash byte 0–7 (byte j on `mcast_hash[8j+7:8j]`).
- R5: In page 2, reads return: 1 ring start, 2 ring stop, 4 transmit page, 0xC receive config, 0xD transmit config, 0xE data config, 0xF interrupt mask. Other non-zero offsets read 0x00, and writes to non-zero offsets change nothing.
- R6: With page code 11 stored, non-zero offsets read 0x00 and writes to them change nothing.
- R7: While the stored stop bit (bit 0) is 1, `offline` rises on the first clock edge at which `link_idle` is 1. It does not rise while `link_idle` is 0.
- R8: When the stored stop bit is 0 and the start bit (bit 1) is 1, `offline` falls on the next clock edge.
- R9: A command write with bit 2 set and bit 0 clear sets the transmit request (`tx_req`, command bit 2) and pulses `tx_go` for one cycle. This happens only while `offline` is 0 and no request is pending. Otherwise bit 2 of the write is ignored. Writing bit 2 as 0 never clears a pending request.
- R10: A pending transmit request clears on the edge where `tx_done` or `tx_abort` is 1.
- R11: A command write whose bits 5:3 are 001 (remote read), 010 (remote write) or 011 (send frame) stores that code on `rdma_op` and pulses `rdma_go` for one cycle.
- R12: A command write whose bits 5:3 are 1xx stores the code and pulses `rdma_abort` for one cycle with no `rdma_go`. A code of 000 leaves the stored field unchanged and gives no pulse.
- R13: `rdma_done` sets the stored remote DMA field to 100, unless the same cycle has a command write with a non-zero field.
- R14: A page 0 write to offset 7 drives `irq_ack` with the written byte for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| link_idle | input | 1 | No receive or transmit in progress |
| tx_done | input | 1 | Transmission completed |
| tx_abort | input | 1 | Transmission aborted |
| rdma_done | input | 1 | Remote DMA completed |
| stat_local_addr | input | 16 | Current local DMA address |
| stat_remote_addr | input | 16 | Current remote DMA address |
| stat_tx | input | 8 | Transmit status |
| stat_coll | input | 8 | Collision count |
| stat_fifo | input | 8 | FIFO byte |
| stat_irq | input | 8 | Interrupt status |
| stat_rx | input | 8 | Receive status |
| stat_tally | input | 24 | Three tally counter bytes |
| offline | output | 1 | Controller in the stopped state |
| tx_req | output | 1 | Transmit request pending |
| tx_go | output | 1 | One-cycle transmit start |
| rdma_op | output | 3 | Stored remote DMA field |
| rdma_go | output | 1 | One-cycle remote DMA start |
| rdma_abort | output | 1 | One-cycle remote DMA abort |
| irq_ack | output | 8 | One-cycle interrupt acknowledge bits |
| cfg_ring_start | output | 8 | Receive ring first page |
| cfg_ring_stop | output | 8 | Receive ring end page |
| cfg_boundary | output | 8 | Boundary page |
| cfg_tx_page | output | 8 | Transmit buffer page |
| cfg_tx_count | output | 16 | Transmit byte count |
| cfg_rmt_start | output | 16 | Remote DMA start address |
| cfg_rmt_count | output | 16 | Remote DMA byte count |
| cfg_rx | output | 8 | Receive configuration |
| cfg_tx | output | 8 | Transmit configuration |
| cfg_data | output | 8 | Data configuration |
| cfg_irq_mask | output | 8 | Interrupt mask |
| station_addr | output | 48 | Station address bytes |
| rx_cur_page | output | 8 | Current receive page |
| mcast_hash | output | 64 | Multicast hash filter |

## Verification
Some rules are checked on every cycle. The reserved page reads zero and offset 0 always shows the command byte. The offline flag holds while the link is busy and falls once start is stored. A transmit start comes only with a pending request and only from the online state. A pending request clears on completion. The two remote DMA strobes never coincide, and completion returns the field to the abort code. Other behaviour needs the bench's scenarios. These include the split read and write decode of page 0, and that page 1 stores bytes where page 2 reads them back. They also cover writes dropped in pages 2 and 3, which only show up when the data is read later through another page. The bench also checks that a transmit request written while offline is dropped, and that writing the field as 000 keeps the previous code.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
    localparam int DW         = 8;
    localparam int AW         = 4;
    localparam int STA_BYTES  = 6;
    localparam int HASH_BYTES = 8;
    localparam int STA_BASE   = 1;
    localparam int CURPG_OFS  = 7;
    localparam int HASH_BASE  = 8;
    localparam int TALLY_N    = 3;
    localparam logic [DW-1:0] CMD_RESET = 8'h21;

    typedef enum logic [1:0] {
        PG_ZERO = 2'b00,
        PG_ONE  = 2'b01,
        PG_TWO  = 2'b10,
        PG_RSV  = 2'b11
    } page_e;

    localparam logic [2:0] RD_NONE  = 3'b000;
    localparam logic [2:0] RD_ABORT = 3'b100;

    typedef struct packed {
        page_e      page;
        logic [2:0] rdma;
        logic       txp;
        logic       sta;
        logic       stp;
    } cmd_t;

    typedef struct packed {
        logic [7:0]  ring_start;
        logic [7:0]  ring_stop;
        logic [7:0]  boundary;
        logic [7:0]  tx_page;
        logic [15:0] tx_count;
        logic [15:0] rmt_start;
        logic [15:0] rmt_count;
        logic [7:0]  rx_cfg;
        logic [7:0]  tx_cfg;
        logic [7:0]  data_cfg;
        logic [7:0]  irq_mask;
    } cfg_t;

    typedef struct packed {
        logic [15:0]          local_addr;
        logic [15:0]          remote_addr;
        logic [7:0]           tx_stat;
        logic [7:0]           coll_cnt;
        logic [7:0]           fifo_byte;
        logic [7:0]           irq_stat;
        logic [7:0]           rx_stat;
        logic [8*TALLY_N-1:0] tally;
    } stat_t;

    function automatic logic rdma_starts(input logic [2:0] f);
        return (f[2] == 1'b0) && (f != RD_NONE);
    endfunction

    function automatic logic rdma_aborts(input logic [2:0] f);
        return f[2];
    endfunction

    function automatic logic [7:0] half16(input logic [15:0] v, input logic hi);
        return hi ? v[15:8] : v[7:0];
    endfunction
endpackage

// File: rtl/pgb_cmd_ctrl.sv
module pgb_cmd_ctrl
    import pgb_pkg::*;
#(
    parameter logic [DW-1:0] CMD_INIT = CMD_RESET
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_cmd,
    input  logic [DW-1:0] wr_data,
    input  logic          link_idle,
    input  logic          tx_done,
    input  logic          tx_abort,
    input  logic          rdma_done,
    output cmd_t          cmd_q,
    output logic          offline_q,
    output logic          tx_go,
    output logic          rdma_go,
    output logic          rdma_abort
);
    cmd_t wcmd;
    cmd_t cmd_d;
    logic offline_d;
    logic txp_accept;

    always_comb begin
        wcmd       = cmd_t'(wr_data);
        txp_accept = wr_cmd && wcmd.txp && !wcmd.stp && !offline_q && !cmd_q.txp;

        cmd_d = cmd_q;
        if (cmd_q.txp && (tx_done || tx_abort))
            cmd_d.txp = 1'b0;
        if (rdma_done)
            cmd_d.rdma = RD_ABORT;
        if (wr_cmd) begin
            cmd_d.page = wcmd.page;
            cmd_d.sta  = wcmd.sta;
            cmd_d.stp  = wcmd.stp;
            if (wcmd.rdma != RD_NONE)
                cmd_d.rdma = wcmd.rdma;
            if (txp_accept)
                cmd_d.txp = 1'b1;
        end

        offline_d = offline_q;
        if (cmd_q.stp) begin
            if (link_idle)
                offline_d = 1'b1;
        end else if (cmd_q.sta) begin
            offline_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= cmd_t'(CMD_INIT);
            offline_q  <= 1'b1;
            tx_go      <= 1'b0;
            rdma_go    <= 1'b0;
            rdma_abort <= 1'b0;
        end else begin
            cmd_q      <= cmd_d;
            offline_q  <= offline_d;
            tx_go      <= txp_accept;
            rdma_go    <= wr_cmd && rdma_starts(wcmd.rdma);
            rdma_abort <= wr_cmd && rdma_aborts(wcmd.rdma);
        end
    end
endmodule

// File: rtl/pgb_cfg_store.sv
module pgb_cfg_store
    import pgb_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [AW-1:0]                      addr,
    input  logic [DW-1:0]                      wr_data,
    input  page_e                              page,
    output cfg_t                               cfg,
    output logic [STA_BYTES-1:0][DW-1:0]       sta,
    output logic [DW-1:0]                      cur_page,
    output logic [HASH_BYTES-1:0][DW-1:0]      hash,
    output logic [DW-1:0]                      irq_ack
);
    logic wr_p0;
    logic wr_p1;

    assign wr_p0 = wr_en && (page == PG_ZERO) && (addr != '0);
    assign wr_p1 = wr_en && (page == PG_ONE)  && (addr != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            irq_ack <= '0;
        end else begin
            irq_ack <= '0;
            if (wr_p0) begin
                case (addr)
                    4'h1: cfg.ring_start      <= wr_data;
                    4'h2: cfg.ring_stop       <= wr_data;
                    4'h3: cfg.boundary        <= wr_data;
                    4'h4: cfg.tx_page         <= wr_data;
                    4'h5: cfg.tx_count[7:0]   <= wr_data;
                    4'h6: cfg.tx_count[15:8]  <= wr_data;
                    4'h7: irq_ack             <= wr_data;
                    4'h8: cfg.rmt_start[7:0]  <= wr_data;
                    4'h9: cfg.rmt_start[15:8] <= wr_data;
                    4'hA: cfg.rmt_count[7:0]  <= wr_data;
                    4'hB: cfg.rmt_count[15:8] <= wr_data;
                    4'hC: cfg.rx_cfg          <= wr_data;
                    4'hD: cfg.tx_cfg          <= wr_data;
                    4'hE: cfg.data_cfg        <= wr_data;
                    4'hF: cfg.irq_mask        <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    for (genvar i = 0; i < STA_BYTES; i++) begin : g_sta
        always_ff @(posedge clk) begin
            if (rst)
                sta[i] <= '0;
            else if (wr_p1 && addr == 4'(STA_BASE + i))
                sta[i] <= wr_data;
        end
    end

    for (genvar j = 0; j < HASH_BYTES; j++) begin : g_hash
        always_ff @(posedge clk) begin
            if (rst)
                hash[j] <= '0;
            else if (wr_p1 && addr == 4'(HASH_BASE + j))
                hash[j] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_page <= '0;
        else if (wr_p1 && addr == 4'(CURPG_OFS))
            cur_page <= wr_data;
    end
endmodule

// File: rtl/pgb_read_mux.sv
module pgb_read_mux
    import pgb_pkg::*;
(
    input  logic [AW-1:0]                 addr,
    input  cmd_t                          cmd,
    input  cfg_t                          cfg,
    input  stat_t                         stat,
    input  logic [STA_BYTES-1:0][DW-1:0]  sta,
    input  logic [DW-1:0]                 cur_page,
    input  logic [HASH_BYTES-1:0][DW-1:0] hash,
    output logic [DW-1:0]                 rd_data
);
    logic [DW-1:0] p0_val;
    logic [DW-1:0] p1_val;
    logic [DW-1:0] p2_val;

    always_comb begin
        case (addr)
            4'h1: p0_val = half16(stat.local_addr, 1'b0);
            4'h2: p0_val = half16(stat.local_addr, 1'b1);
            4'h3: p0_val = cfg.boundary;
            4'h4: p0_val = stat.tx_stat;
            4'h5: p0_val = stat.coll_cnt;
            4'h6: p0_val = stat.fifo_byte;
            4'h7: p0_val = stat.irq_stat;
            4'h8: p0_val = half16(stat.remote_addr, 1'b0);
            4'h9: p0_val = half16(stat.remote_addr, 1'b1);
            4'hC: p0_val = stat.rx_stat;
            4'hD: p0_val = stat.tally[7:0];
            4'hE: p0_val = stat.tally[15:8];
            4'hF: p0_val = stat.tally[23:16];
            default: p0_val = '0;
        endcase
    end

    always_comb begin
        p1_val = '0;
        if (addr == 4'(CURPG_OFS))
            p1_val = cur_page;
        for (int i = 0; i < STA_BYTES; i++)
            if (addr == 4'(STA_BASE + i))
                p1_val = sta[i];
        for (int j = 0; j < HASH_BYTES; j++)
            if (addr == 4'(HASH_BASE + j))
                p1_val = hash[j];
    end

    always_comb begin
        case (addr)
            4'h1: p2_val = cfg.ring_start;
            4'h2: p2_val = cfg.ring_stop;
            4'h4: p2_val = cfg.tx_page;
            4'hC: p2_val = cfg.rx_cfg;
            4'hD: p2_val = cfg.tx_cfg;
            4'hE: p2_val = cfg.data_cfg;
            4'hF: p2_val = cfg.irq_mask;
            default: p2_val = '0;
        endcase
    end

    always_comb begin
        if (addr == '0) begin
            rd_data = cmd;
        end else begin
            case (cmd.page)
                PG_ZERO: rd_data = p0_val;
                PG_ONE:  rd_data = p1_val;
                PG_TWO:  rd_data = p2_val;
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/pgb_bank.sv
module pgb_bank
    import pgb_pkg::*;
#(
    parameter logic [7:0] CMD_INIT = pgb_pkg::CMD_RESET
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  addr,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic        link_idle,
    input  logic        tx_done,
    input  logic        tx_abort,
    input  logic        rdma_done,
    input  logic [15:0] stat_local_addr,
    input  logic [15:0] stat_remote_addr,
    input  logic [7:0]  stat_tx,
    input  logic [7:0]  stat_coll,
    input  logic [7:0]  stat_fifo,
    input  logic [7:0]  stat_irq,
    input  logic [7:0]  stat_rx,
    input  logic [23:0] stat_tally,
    output logic        offline,
    output logic        tx_req,
    output logic        tx_go,
    output logic [2:0]  rdma_op,
    output logic        rdma_go,
    output logic        rdma_abort,
    output logic [7:0]  irq_ack,
    output logic [7:0]  cfg_ring_start,
    output logic [7:0]  cfg_ring_stop,
    output logic [7:0]  cfg_boundary,
    output logic [7:0]  cfg_tx_page,
    output logic [15:0] cfg_tx_count,
    output logic [15:0] cfg_rmt_start,
    output logic [15:0] cfg_rmt_count,
    output logic [7:0]  cfg_rx,
    output logic [7:0]  cfg_tx,
    output logic [7:0]  cfg_data,
    output logic [7:0]  cfg_irq_mask,
    output logic [47:0] station_addr,
    output logic [7:0]  rx_cur_page,
    output logic [63:0] mcast_hash
);
    cmd_t                          cmd_r;
    cfg_t                          cfg_r;
    stat_t                         stat_w;
    logic [STA_BYTES-1:0][DW-1:0]  sta_r;
    logic [HASH_BYTES-1:0][DW-1:0] hash_r;
    logic [DW-1:0]                 cur_page_r;
    logic                          wr_cmd;
    logic [7:0]                    cmd_byte;

    assign wr_cmd   = wr_en && (addr == '0);
    assign cmd_byte = cmd_r;

    always_comb begin
        stat_w.local_addr  = stat_local_addr;
        stat_w.remote_addr = stat_remote_addr;
        stat_w.tx_stat     = stat_tx;
        stat_w.coll_cnt    = stat_coll;
        stat_w.fifo_byte   = stat_fifo;
        stat_w.irq_stat    = stat_irq;
        stat_w.rx_stat     = stat_rx;
        stat_w.tally       = stat_tally;
    end

    pgb_cmd_ctrl #(.CMD_INIT(CMD_INIT)) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .wr_cmd     (wr_cmd),
        .wr_data    (wr_data),
        .link_idle  (link_idle),
        .tx_done    (tx_done),
        .tx_abort   (tx_abort),
        .rdma_done  (rdma_done),
        .cmd_q      (cmd_r),
        .offline_q  (offline),
        .tx_go      (tx_go),
        .rdma_go    (rdma_go),
        .rdma_abort (rdma_abort)
    );

    pgb_cfg_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .page     (cmd_r.page),
        .cfg      (cfg_r),
        .sta      (sta_r),
        .cur_page (cur_page_r),
        .hash     (hash_r),
        .irq_ack  (irq_ack)
    );

    pgb_read_mux u_rd (
        .addr     (addr),
        .cmd      (cmd_r),
        .cfg      (cfg_r),
        .stat     (stat_w),
        .sta      (sta_r),
        .cur_page (cur_page_r),
        .hash     (hash_r),
        .rd_data  (rd_data)
    );

    assign tx_req         = cmd_r.txp;
    assign rdma_op        = cmd_r.rdma;
    assign cfg_ring_start = cfg_r.ring_start;
    assign cfg_ring_stop  = cfg_r.ring_stop;
    assign cfg_boundary   = cfg_r.boundary;
    assign cfg_tx_page    = cfg_r.tx_page;
    assign cfg_tx_count   = cfg_r.tx_count;
    assign cfg_rmt_start  = cfg_r.rmt_start;
    assign cfg_rmt_count  = cfg_r.rmt_count;
    assign cfg_rx         = cfg_r.rx_cfg;
    assign cfg_tx         = cfg_r.tx_cfg;
    assign cfg_data       = cfg_r.data_cfg;
    assign cfg_irq_mask   = cfg_r.irq_mask;
    assign station_addr   = sta_r;
    assign rx_cur_page    = cur_page_r;
    assign mcast_hash     = hash_r;
endmodule

// File: rtl/pgb_bank_chk.sv
module pgb_bank_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] addr,
    input logic       wr_en,
    input logic [7:0] rd_data,
    input logic [7:0] cmd_byte,
    input logic       link_idle,
    input logic       tx_done,
    input logic       tx_abort,
    input logic       rdma_done,
    input logic       offline,
    input logic       tx_req,
    input logic       tx_go,
    input logic [2:0] rdma_op,
    input logic       rdma_go,
    input logic       rdma_abort
);
    AST_RESET_CMD: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmd_byte == 8'h21) && offline); // R1

    AST_CMD_EVERY_PAGE: assert property (@(posedge clk) disable iff (rst)
        (addr == 4'h0) |-> (rd_data == cmd_byte)); // R2

    AST_RSV_PAGE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cmd_byte[7:6] == 2'b11 && addr != 4'h0) |-> (rd_data == 8'h00)); // R6

    AST_STOP_WAITS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!offline && !link_idle) |=> !offline); // R7

    AST_START_LEAVES: assert property (@(posedge clk) disable iff (rst)
        (!cmd_byte[0] && cmd_byte[1]) |=> !offline); // R8

    AST_TXGO_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        tx_go |-> tx_req); // R9

    AST_TXGO_ONLINE: assert property (@(posedge clk) disable iff (rst)
        tx_go |-> $past(!offline)); // R9

    AST_TXREQ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (tx_req && (tx_done || tx_abort)) |=> !tx_req); // R10

    AST_RDMA_GO_CODE: assert property (@(posedge clk) disable iff (rst)
        rdma_go |-> (rdma_op != 3'b000) && !rdma_op[2]); // R11

    AST_RDMA_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rdma_go, rdma_abort})); // R12

    AST_ABORT_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        rdma_abort |-> $past(wr_en && addr == 4'h0)); // R12

    AST_DONE_IDLES: assert property (@(posedge clk) disable iff (rst)
        (rdma_done && !(wr_en && addr == 4'h0)) |=> (rdma_op == 3'b100)); // R13
endmodule

bind pgb_bank pgb_bank_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .cmd_byte   (cmd_byte),
    .link_idle  (link_idle),
    .tx_done    (tx_done),
    .tx_abort   (tx_abort),
    .rdma_done  (rdma_done),
    .offline    (offline),
    .tx_req     (tx_req),
    .tx_go      (tx_go),
    .rdma_op    (rdma_op),
    .rdma_go    (rdma_go),
    .rdma_abort (rdma_abort)
);

// File: tb/pgb_bank_test.sv
module pgb_bank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        link_idle = 1'b1;
    logic        tx_done = 1'b0;
    logic        tx_abort = 1'b0;
    logic        rdma_done = 1'b0;
    logic [15:0] s_local = 16'hA1B2;
    logic [15:0] s_remote = 16'hC3D4;
    logic [7:0]  s_tx = 8'h11, s_coll = 8'h22, s_fifo = 8'h33, s_irq = 8'h44, s_rx = 8'h55;
    logic [23:0] s_tally = 24'h887766;
    logic        offline, tx_req, tx_go, rdma_go, rdma_abort;
    logic [2:0]  rdma_op;
    logic [7:0]  irq_ack;
    logic [7:0]  c_rs, c_rp, c_bd, c_tp, c_rx, c_tx, c_dc, c_im, cur_pg;
    logic [15:0] c_tc, c_ms, c_mc;
    logic [47:0] sta_out;
    logic [63:0] hash_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_p0 [16];
    logic [7:0] m_p1 [16];
    logic [7:0] m_cmd;

    always #10 clk = ~clk;

    pgb_bank uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .link_idle(link_idle), .tx_done(tx_done),
        .tx_abort(tx_abort), .rdma_done(rdma_done),
        .stat_local_addr(s_local), .stat_remote_addr(s_remote), .stat_tx(s_tx),
        .stat_coll(s_coll), .stat_fifo(s_fifo), .stat_irq(s_irq), .stat_rx(s_rx),
        .stat_tally(s_tally), .offline(offline), .tx_req(tx_req), .tx_go(tx_go),
        .rdma_op(rdma_op), .rdma_go(rdma_go), .rdma_abort(rdma_abort),
        .irq_ack(irq_ack), .cfg_ring_start(c_rs), .cfg_ring_stop(c_rp),
        .cfg_boundary(c_bd), .cfg_tx_page(c_tp), .cfg_tx_count(c_tc),
        .cfg_rmt_start(c_ms), .cfg_rmt_count(c_mc), .cfg_rx(c_rx), .cfg_tx(c_tx),
        .cfg_data(c_dc), .cfg_irq_mask(c_im), .station_addr(sta_out),
        .rx_cur_page(cur_pg), .mcast_hash(hash_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] pg, input logic [3:0] a);
        if (a == 4'h0) return m_cmd;
        case (pg)
            2'b00: case (a)
                4'h1: return s_local[7:0];
                4'h2: return s_local[15:8];
                4'h3: return m_p0[3];
                4'h4: return s_tx;
                4'h5: return s_coll;
                4'h6: return s_fifo;
                4'h7: return s_irq;
                4'h8: return s_remote[7:0];
                4'h9: return s_remote[15:8];
                4'hC: return s_rx;
                4'hD: return s_tally[7:0];
                4'hE: return s_tally[15:8];
                4'hF: return s_tally[23:16];
                default: return 8'h00;
            endcase
            2'b01: return m_p1[a];
            2'b10: case (a)
                4'h1, 4'h2, 4'h4, 4'hC, 4'hD, 4'hE, 4'hF: return m_p0[a];
                default: return 8'h00;
            endcase
            default: return 8'h00;
        endcase
    endfunction

    function automatic string page_req(input logic [1:0] pg, input logic [3:0] a);
        if (a == 4'h0) return "R2";
        case (pg)
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) begin m_p0[i] = 8'h00; m_p1[i] = 8'h00; end
        m_cmd = 8'h21;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        do_read(4'h0, r);
        check("R1 cmd reset", r, 8'h21);
        check("R1 offline reset", offline, 1'b1);
        check("R1 config reset", {c_rs, c_tc, c_ms, c_im, cur_pg}, '0);
        check("R1 table reset", {sta_out, hash_out}, '0);

        // R8 start leaves offline, R7 stop waits for idle
        link_idle = 1'b0;
        do_write(4'h0, 8'h02);
        check("R8 offline one edge after store", offline, 1'b1);
        tick(1);
        check("R8 online after start", offline, 1'b0);

        // R9 transmit request
        do_write(4'h0, 8'h06);
        check("R9 tx_go pulse", tx_go, 1'b1);
        check("R9 tx_req set", tx_req, 1'b1);
        tick(1);
        check("R9 tx_go single cycle", tx_go, 1'b0);
        do_write(4'h0, 8'h02);
        check("R9 zero write keeps request", tx_req, 1'b1);
        check("R9 no second pulse", tx_go, 1'b0);

        // R10 completion clears
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
        check("R10 tx_done clears", tx_req, 1'b0);
        do_write(4'h0, 8'h06);
        @(negedge clk); tx_abort = 1'b1;
        @(negedge clk); tx_abort = 1'b0;
        check("R10 tx_abort clears", tx_req, 1'b0);

        // R7 stop held off by busy link
        do_write(4'h0, 8'h01);
        tick(3);
        check("R7 busy link keeps online", offline, 1'b0);
        link_idle = 1'b1;
        tick(1);
        check("R7 offline after idle", offline, 1'b1);

        // R9 request while offline ignored
        do_write(4'h0, 8'h06);
        check("R9 offline tx_go", tx_go, 1'b0);
        check("R9 offline tx_req", tx_req, 1'b0);
        tick(1);
        check("R8 online again", offline, 1'b0);

        // R11 R12 R13 remote DMA field
        do_write(4'h0, 8'h0A);
        check("R11 rdma_go read", rdma_go, 1'b1);
        check("R11 rdma_op read", rdma_op, 3'b001);
        check("R12 no abort on start", rdma_abort, 1'b0);
        do_write(4'h0, 8'h02);
        check("R12 code 000 keeps field", rdma_op, 3'b001);
        check("R12 code 000 no pulse", {rdma_go, rdma_abort}, 2'b00);
        do_write(4'h0, 8'h22);
        check("R12 abort pulse", {rdma_go, rdma_abort}, 2'b01);
        tick(1);
        check("R12 abort single cycle", rdma_abort, 1'b0);
        do_write(4'h0, 8'h1A);
        check("R11 send frame", {rdma_go, rdma_op}, {1'b1, 3'b011});
        @(negedge clk); rdma_done = 1'b1;
        @(negedge clk); rdma_done = 1'b0;
        check("R13 done returns to abort code", rdma_op, 3'b100);

        // R14 interrupt acknowledge
        do_write(4'h7, 8'h5A);
        check("R14 irq_ack pulse", irq_ack, 8'h5A);
        tick(1);
        check("R14 irq_ack single cycle", irq_ack, 8'h00);

        // stop the controller for the random phase
        do_write(4'h0, 8'h01);
        m_cmd = 8'h21;

        // random phase: R2..R6
        for (int it = 0; it < 400; it++) begin
            logic [1:0] pg;
            logic [3:0] wa, ra;
            logic [7:0] wd, got;
            pg = 2'($urandom_range(0, 3));
            do_write(4'h0, {pg, 6'b000001});
            m_cmd = {pg, 6'b100001};
            wa = 4'($urandom_range(1, 15));
            wd = 8'($urandom);
            do_write(wa, wd);
            if (pg == 2'b00 && wa != 4'h7) m_p0[wa] = wd;
            if (pg == 2'b01) m_p1[wa] = wd;
            ra = (it % 3 == 0) ? wa : 4'($urandom_range(0, 15));
            do_read(ra, got);
            check(page_req(pg, ra), got, exp_read(pg, ra));
        end

        // sweep every offset of every page against the model
        for (int p = 0; p < 4; p++) begin
            do_write(4'h0, {2'(p), 6'b000001});
            m_cmd = {2'(p), 6'b100001};
            for (int a = 0; a < 16; a++) begin
                logic [7:0] got;
                do_read(4'(a), got);
                check(page_req(2'(p), 4'(a)), got, exp_read(2'(p), 4'(a)));
            end
        end

        // configuration and table outputs
        check("R3 ring/boundary/txpage", {c_rs, c_rp, c_bd, c_tp}, {m_p0[1], m_p0[2], m_p0[3], m_p0[4]});
        check("R3 counts", {c_tc, c_ms, c_mc}, {m_p0[6], m_p0[5], m_p0[9], m_p0[8], m_p0[11], m_p0[10]});
        check("R3 config bytes", {c_rx, c_tx, c_dc, c_im}, {m_p0[12], m_p0[13], m_p0[14], m_p0[15]});
        check("R4 station", sta_out, {m_p1[6], m_p1[5], m_p1[4], m_p1[3], m_p1[2], m_p1[1]});
        check("R4 current page", cur_pg, m_p1[7]);
        check("R4 hash", hash_out, {m_p1[15], m_p1[14], m_p1[13], m_p1[12], m_p1[11], m_p1[10], m_p1[9], m_p1[8]});

        finish_run();
    end
endmodule